// File: doc/BRIEF.md
# Expanded Memory Port Register File

This block is the I/O-side register front end of a paged expanded-memory adapter. It watches an eight-byte I/O window and accepts byte and word reads and writes there. Inside the window sit a translate-table index, two block-number ports, a bank identifier and a control byte. The block also owns the translate table, which is a synchronous RAM with one 16-bit block number per index.

Every time the index changes, the block fetches the table entry at the new index and loads it into both block ports. A word write to the plain block port, or to the auto-incrementing block port, stores the value into the table. It also sends an update request (index and value) to the downstream translation-entry builder. The auto-incrementing port then steps the index and refetches, so software can stream a run of consecutive entries.

The bank identifier and the enable bit of the control byte drive the bank-select outputs. A request whose address falls outside the window is not claimed: the block flags it for pass-through and changes no state.

Top module: `xmem_port_regs`

## Requirements
- R1: A request with an address below 0x31A0 or above 0x31A7 raises `io_pass` in the following cycle. It produces no read data and no update request, and it leaves every register unchanged.
- R2: The window is laid out as follows. Byte offset 0/1 is the index (little-endian). 2/3 is the plain block port. 4/5 is the auto-increment block port. 6 is the bank byte and 7 is the control byte. A byte read returns the addressed byte in bits 7:0 with bits 15:8 zero. A word read ignores address bit 0 and returns the even-offset byte in bits 7:0 and the odd-offset byte in bits 15:8.
- R3: Only the low 12 bits of the index, the low 4 bits of the bank byte and the low 4 bits of the control byte are kept. The other bits read back as zero.
- R4: A word write at offset 0, or a byte write at offset 0 or 1, changes the index. After that write, `busy` is high for exactly one cycle, and then both block ports hold the table entry at the new index.
- R5: A word write at offset 2 loads the value into both block ports and stores it in the table at the current index.
- R6: A word write at offset 4 stores the value in the table at the current index and increments the index modulo 4096, so 0xFFF wraps to 0. Both block ports are then reloaded from the table at the new index.
- R7: A word read at offset 4 returns the value the port held before the access. The index is then incremented and both block ports are reloaded from the table.
- R8: After reset, the control byte is 0x02, `map_en` is 1 and `map_bank` is 0. `map_en` and `map_bank` change only on a write that touches offset 6 or 7. After such a write, `map_bank` equals the bank byte and `map_en` equals control bit 1.
- R9: While `busy` is high, a request is ignored. It produces no read data, no pass-through flag, no update request and no register change.
- R10: A word write at offset 2 or 4 pulses `upd_valid` in the following cycle. During that pulse, `upd_index` holds the index at the time of the write and `upd_block` holds the written value.
- R11: A read inside the window pulses `io_rvalid` in the cycle after it is accepted, with the read data on `io_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Access request, one cycle per access |
| io_wr | input | 1 | 1 for write, 0 for read |
| io_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| io_rdata | output | 16 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid pulse |
| io_pass | output | 1 | Request was outside the window and not claimed |
| busy | output | 1 | Block-port reload in progress; requests ignored |
| upd_valid | output | 1 | Table update request pulse |
| upd_index | output | 12 | Table index of the update |
| upd_block | output | 16 | Block number of the update |
| map_en | output | 1 | Bank mapping enabled |
| map_bank | output | 4 | Selected bank |

## Verification
Read data, the pass-through flag and the update request all come from registers set at the accepting edge, so they are due one cycle after the request. Reloaded block-port values are due one edge later, after the one-cycle `busy` window. The bench drives on falling edges and samples each access's single-cycle results at the next falling edge. When it sees `busy`, it waits out that cycle before the next access, so each read that follows an index change observes the refilled ports. The scoreboard pushes expected read words when a read is issued and pops them only on `io_rvalid`, so a missing or extra read-data pulse is itself a mismatch.

// File: rtl/xmem_pkg.sv
`timescale 1ns/1ps
package xmem_pkg;

    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 8;
    localparam int OFF_W     = $clog2(WIN_BYTES);

    // Byte offsets inside the window; the ordering is decoded by software.
    localparam logic [OFF_W-1:0] OFF_IDX_LO = 3'd0;
    localparam logic [OFF_W-1:0] OFF_IDX_HI = 3'd1;
    localparam logic [OFF_W-1:0] OFF_BLK_LO = 3'd2;
    localparam logic [OFF_W-1:0] OFF_BLK_HI = 3'd3;
    localparam logic [OFF_W-1:0] OFF_INC_LO = 3'd4;
    localparam logic [OFF_W-1:0] OFF_INC_HI = 3'd5;
    localparam logic [OFF_W-1:0] OFF_BANK   = 3'd6;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd7;

endpackage

// File: rtl/xmem_win_decode.sv
`timescale 1ns/1ps
module xmem_win_decode
    import xmem_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h31A0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BASE + ADDR_W'(WIN_BYTES - 1));

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel = addr - BASE;
        hit = (addr >= BASE) && (addr <= LAST);
        off = rel[OFF_W-1:0];
    end
endmodule

// File: rtl/xmem_rd_mux.sv
`timescale 1ns/1ps
module xmem_rd_mux
    import xmem_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int BANK_W = 4,
    parameter int CTRL_W = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] blk,
    input  logic [WORD_W-1:0] blk_inc,
    input  logic [BANK_W-1:0] bank,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [OFF_W-1:0]  off,
    input  logic              word,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] idx_ext;
    logic [BYTE_W-1:0] file_b [WIN_BYTES];
    logic [OFF_W-1:0]  even_off;
    logic [OFF_W-1:0]  odd_off;

    always_comb begin
        idx_ext    = WORD_W'(idx);
        file_b[0]  = idx_ext[7:0];
        file_b[1]  = idx_ext[15:8];
        file_b[2]  = blk[7:0];
        file_b[3]  = blk[15:8];
        file_b[4]  = blk_inc[7:0];
        file_b[5]  = blk_inc[15:8];
        file_b[6]  = BYTE_W'(bank);
        file_b[7]  = BYTE_W'(ctrl);
        even_off   = {off[OFF_W-1:1], 1'b0};
        odd_off    = {off[OFF_W-1:1], 1'b1};
        if (word) rdata = {file_b[odd_off], file_b[even_off]};
        else      rdata = {{BYTE_W{1'b0}}, file_b[off]};
    end
endmodule

// File: rtl/xmem_tt_ram.sv
`timescale 1ns/1ps
module xmem_tt_ram #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xmem_port_regs.sv
`timescale 1ns/1ps
module xmem_port_regs
    import xmem_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE     = 16'h31A0,
    parameter int                IDX_W    = 12,
    parameter int                BANK_W   = 4,
    parameter int                CTRL_W   = 4,
    parameter logic [CTRL_W-1:0] CTRL_RST = 4'h2,
    parameter int                EN_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic              io_word,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    output logic              io_rvalid,
    output logic              io_pass,
    output logic              busy,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_index,
    output logic [15:0]       upd_block,
    output logic              map_en,
    output logic [BANK_W-1:0] map_bank
);
    localparam int IDX_HI_W = IDX_W - BYTE_W;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] blk;
        logic [WORD_W-1:0] blk_inc;
        logic [BANK_W-1:0] bank;
        logic [CTRL_W-1:0] ctrl;
        logic              reload;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
        logic              pass;
        logic              upd_v;
        logic [IDX_W-1:0]  upd_idx;
        logic [WORD_W-1:0] upd_blk;
        logic              map_en;
        logic [BANK_W-1:0] map_bank;
    } port_state_t;

    port_state_t st_d, st_q;

    logic              win_hit;
    logic [OFF_W-1:0]  win_off;
    logic [OFF_W-1:0]  word_off;
    logic [WORD_W-1:0] rd_word;
    logic              accept;
    logic              map_touch;
    logic              ram_we;
    logic [IDX_W-1:0]  ram_waddr;
    logic [WORD_W-1:0] ram_wdata;
    logic              ram_re;
    logic [IDX_W-1:0]  ram_raddr;
    logic [WORD_W-1:0] ram_rdata;
    logic [WORD_W-1:0] blk_cur;
    logic [WORD_W-1:0] blk_inc_cur;

    xmem_win_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_dec (
        .addr (io_addr),
        .hit  (win_hit),
        .off  (win_off)
    );

    xmem_rd_mux #(
        .IDX_W  (IDX_W),
        .BANK_W (BANK_W),
        .CTRL_W (CTRL_W)
    ) u_rmux (
        .idx     (st_q.idx),
        .blk     (st_q.blk),
        .blk_inc (st_q.blk_inc),
        .bank    (st_q.bank),
        .ctrl    (st_q.ctrl),
        .off     (win_off),
        .word    (io_word),
        .rdata   (rd_word)
    );

    xmem_tt_ram #(
        .AW (IDX_W),
        .DW (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign accept   = io_req && !st_q.reload;
    assign word_off = {win_off[OFF_W-1:1], 1'b0};

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.pass   = 1'b0;
        st_d.upd_v  = 1'b0;
        st_d.reload = 1'b0;
        ram_we      = 1'b0;
        ram_waddr   = st_q.idx;
        ram_wdata   = io_wdata;
        map_touch   = 1'b0;

        // Refill of both block ports from the table lands here.
        if (st_q.reload) begin
            st_d.blk     = ram_rdata;
            st_d.blk_inc = ram_rdata;
        end

        if (accept) begin
            if (!win_hit) begin
                st_d.pass = 1'b1;
            end else if (!io_wr) begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = rd_word;
                if (io_word && (word_off == OFF_INC_LO)) begin
                    st_d.idx    = st_q.idx + IDX_W'(1);
                    st_d.reload = 1'b1;
                end
            end else if (io_word) begin
                case (word_off)
                    OFF_IDX_LO: begin
                        st_d.idx    = io_wdata[IDX_W-1:0];
                        st_d.reload = 1'b1;
                    end
                    OFF_BLK_LO: begin
                        st_d.blk     = io_wdata;
                        st_d.blk_inc = io_wdata;
                        ram_we       = 1'b1;
                        st_d.upd_v   = 1'b1;
                        st_d.upd_idx = st_q.idx;
                        st_d.upd_blk = io_wdata;
                    end
                    OFF_INC_LO: begin
                        st_d.blk     = io_wdata;
                        st_d.blk_inc = io_wdata;
                        ram_we       = 1'b1;
                        st_d.upd_v   = 1'b1;
                        st_d.upd_idx = st_q.idx;
                        st_d.upd_blk = io_wdata;
                        st_d.idx     = st_q.idx + IDX_W'(1);
                        st_d.reload  = 1'b1;
                    end
                    default: begin
                        st_d.bank = io_wdata[BANK_W-1:0];
                        st_d.ctrl = io_wdata[BYTE_W +: CTRL_W];
                        map_touch = 1'b1;
                    end
                endcase
            end else begin
                case (win_off)
                    OFF_IDX_LO: begin
                        st_d.idx[BYTE_W-1:0] = io_wdata[BYTE_W-1:0];
                        st_d.reload          = 1'b1;
                    end
                    OFF_IDX_HI: begin
                        st_d.idx[IDX_W-1:BYTE_W] = io_wdata[IDX_HI_W-1:0];
                        st_d.reload              = 1'b1;
                    end
                    OFF_BLK_LO: st_d.blk[7:0]      = io_wdata[7:0];
                    OFF_BLK_HI: st_d.blk[15:8]     = io_wdata[7:0];
                    OFF_INC_LO: st_d.blk_inc[7:0]  = io_wdata[7:0];
                    OFF_INC_HI: st_d.blk_inc[15:8] = io_wdata[7:0];
                    OFF_BANK: begin
                        st_d.bank = io_wdata[BANK_W-1:0];
                        map_touch = 1'b1;
                    end
                    default: begin
                        st_d.ctrl = io_wdata[CTRL_W-1:0];
                        map_touch = 1'b1;
                    end
                endcase
            end

            if (map_touch) begin
                st_d.map_en   = st_d.ctrl[EN_BIT];
                st_d.map_bank = st_d.bank;
            end
        end
    end

    // Fetch is addressed by the next index so the data is ready one cycle on.
    assign ram_re    = st_d.reload;
    assign ram_raddr = st_d.idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ctrl     <= CTRL_RST;
            st_q.map_en   <= CTRL_RST[EN_BIT];
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata    = st_q.rdata;
    assign io_rvalid   = st_q.rvalid;
    assign io_pass     = st_q.pass;
    assign busy        = st_q.reload;
    assign upd_valid   = st_q.upd_v;
    assign upd_index   = st_q.upd_idx;
    assign upd_block   = st_q.upd_blk;
    assign map_en      = st_q.map_en;
    assign map_bank    = st_q.map_bank;
    assign blk_cur     = st_q.blk;
    assign blk_inc_cur = st_q.blk_inc;

endmodule

// File: rtl/xmem_port_regs_chk.sv
`timescale 1ns/1ps
module xmem_port_regs_chk #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h31A0,
    parameter int                BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_req,
    input logic              io_wr,
    input logic              io_word,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rvalid,
    input logic              io_pass,
    input logic              busy,
    input logic              upd_valid,
    input logic              map_en,
    input logic [BANK_W-1:0] map_bank,
    input logic [15:0]       blk_cur,
    input logic [15:0]       blk_inc_cur
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(BASE + ADDR_W'(7));

    logic out_win;
    assign out_win = (io_addr < BASE) || (io_addr > TOP_ADDR);

    a_r1_outside_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !busy && out_win) |=> (io_pass && !io_rvalid && !upd_valid));

    a_r11_rvalid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> $past(io_req && !io_wr && !busy));

    a_r9_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r9_busy_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!io_rvalid && !io_pass && !upd_valid));

    a_r4_ports_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blk_cur == blk_inc_cur));

    a_r10_update_from_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(io_req && io_wr && io_word && !busy));

    a_r8_map_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(map_en) || !$stable(map_bank)) |-> $past(io_req && io_wr && !busy));

endmodule

bind xmem_port_regs xmem_port_regs_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .BANK_W (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_req      (io_req),
    .io_wr       (io_wr),
    .io_word     (io_word),
    .io_addr     (io_addr),
    .io_rvalid   (io_rvalid),
    .io_pass     (io_pass),
    .busy        (busy),
    .upd_valid   (upd_valid),
    .map_en      (map_en),
    .map_bank    (map_bank),
    .blk_cur     (blk_cur),
    .blk_inc_cur (blk_inc_cur)
);

// File: tb/tb_xmem_port_regs.sv
`timescale 1ns/1ps
module tb_xmem_port_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_word = 1'b0;
    logic [15:0] io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        io_rvalid;
    logic        io_pass;
    logic        busy;
    logic        upd_valid;
    logic [11:0] upd_index;
    logic [15:0] upd_block;
    logic        map_en;
    logic [3:0]  map_bank;

    always #2 clk = ~clk;

    xmem_port_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_req    (io_req),
        .io_wr     (io_wr),
        .io_word   (io_word),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .io_rvalid (io_rvalid),
        .io_pass   (io_pass),
        .busy      (busy),
        .upd_valid (upd_valid),
        .upd_index (upd_index),
        .upd_block (upd_block),
        .map_en    (map_en),
        .map_bank  (map_bank)
    );

    typedef struct {
        logic [15:0] v;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    logic        l_pass, l_upd, l_busy;
    logic [11:0] l_uidx;
    logic [15:0] l_ublk;

    function automatic logic [15:0] wa(input int off);
        return 16'h31A0 + 16'(off);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every read-data pulse.
    always @(negedge clk) begin
        if (rst_n && io_rvalid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R11 unexpected read data", io_rdata, 16'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(io_rdata == e.v, e.tag, io_rdata, e.v);
            end
        end
    end

    task automatic acc(input bit wr, input bit word, input logic [15:0] addr,
                       input logic [15:0] data);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_word = word; io_addr = addr; io_wdata = data;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
        l_pass = io_pass; l_upd = upd_valid; l_uidx = upd_index;
        l_ublk = upd_block; l_busy = busy;
        if (busy) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] addr, input bit word,
                      input logic [15:0] exp, input string tag);
        q.push_back('{exp, tag});
        acc(1'b0, word, addr, 16'h0);
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog", 16'h0, 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(map_en == 1'b1, "R8 reset map_en", 16'(map_en), 16'h1);
        chk(map_bank == 4'h0, "R8 reset map_bank", 16'(map_bank), 16'h0);
        chk(busy == 1'b0, "R4 reset busy", 16'(busy), 16'h0);
        rd(wa(7), 1'b0, 16'h0002, "R8 reset control byte");
        rd(wa(0), 1'b1, 16'h0000, "R2 reset index word");

        // Fill entries 0..5 through the auto-increment port (R6, R10)
        acc(1'b1, 1'b1, wa(0), 16'h0000);
        chk(l_busy == 1'b1, "R4 busy after index write", 16'(l_busy), 16'h1);
        for (int k = 0; k < 6; k++) begin
            acc(1'b1, 1'b1, wa(4), 16'hA000 + 16'(k));
            chk(l_upd == 1'b1, "R10 update pulse on offset-4 write", 16'(l_upd), 16'h1);
            chk(l_uidx == 12'(k), "R10 update index", 16'(l_uidx), 16'(k));
            chk(l_ublk == 16'hA000 + 16'(k), "R10 update block", l_ublk, 16'hA000 + 16'(k));
        end
        rd(wa(0), 1'b1, 16'h0006, "R6 index stepped by offset-4 writes");

        // Index change reloads both ports (R4)
        acc(1'b1, 1'b1, wa(0), 16'h0002);
        rd(wa(2), 1'b1, 16'hA002, "R4 plain port reloaded");
        rd(wa(4), 1'b1, 16'hA002, "R7 auto port read returns current entry");
        rd(wa(4), 1'b1, 16'hA003, "R7 auto port read after increment");
        rd(wa(0), 1'b1, 16'h0004, "R7 index stepped by offset-4 reads");

        // Offset-2 word write (R5, R10)
        acc(1'b1, 1'b1, wa(2), 16'hBEEF);
        chk(l_upd == 1'b1 && l_uidx == 12'h004, "R10 update on offset-2 write",
            16'(l_uidx), 16'h0004);
        chk(l_busy == 1'b0, "R5 offset-2 write causes no reload", 16'(l_busy), 16'h0);
        rd(wa(2), 1'b1, 16'hBEEF, "R5 plain port holds written value");
        rd(wa(4), 1'b1, 16'hBEEF, "R5 auto port mirrors written value");
        acc(1'b1, 1'b0, wa(0), 16'h0004);
        chk(l_busy == 1'b1, "R4 busy after index byte write", 16'(l_busy), 16'h1);
        rd(wa(2), 1'b1, 16'hBEEF, "R5 table holds offset-2 value");

        // Byte and odd-address word reads (R2)
        rd(wa(2), 1'b0, 16'h00EF, "R2 byte read low");
        rd(wa(3), 1'b0, 16'h00BE, "R2 byte read high");
        rd(wa(3), 1'b1, 16'hBEEF, "R2 word read at odd address");
        rd(wa(4), 1'b0, 16'h00EF, "R2 byte read auto port low");

        // Masking (R3) and control (R8)
        acc(1'b1, 1'b1, wa(0), 16'hF005);
        rd(wa(0), 1'b1, 16'h0005, "R3 index upper bits dropped");
        rd(wa(2), 1'b1, 16'hA005, "R4 reload after masked index write");
        acc(1'b1, 1'b0, wa(1), 16'h00FF);
        rd(wa(0), 1'b1, 16'h0F05, "R3 index high byte keeps 4 bits");
        acc(1'b1, 1'b0, wa(6), 16'h00A7);
        chk(map_bank == 4'h7 && map_en, "R8 bank write updates map", 16'(map_bank), 16'h7);
        rd(wa(6), 1'b0, 16'h0007, "R3 bank upper bits dropped");
        acc(1'b1, 1'b0, wa(7), 16'h00F0);
        chk(map_en == 1'b0, "R8 enable bit cleared", 16'(map_en), 16'h0);
        rd(wa(7), 1'b0, 16'h0000, "R3 control upper bits dropped");
        acc(1'b1, 1'b1, wa(6), 16'h0203);
        chk(map_en == 1'b1 && map_bank == 4'h3, "R8 word write bank and control",
            {11'h0, map_en, map_bank}, 16'h0013);
        rd(wa(6), 1'b1, 16'h0203, "R2 bank and control word read");

        // Index wrap (R6)
        acc(1'b1, 1'b1, wa(0), 16'h0FFF);
        acc(1'b1, 1'b1, wa(4), 16'h1234);
        chk(l_uidx == 12'hFFF, "R10 update index at top entry", 16'(l_uidx), 16'h0FFF);
        rd(wa(0), 1'b1, 16'h0000, "R6 index wraps to zero");
        rd(wa(2), 1'b1, 16'hA000, "R6 reload after wrap");
        acc(1'b1, 1'b1, wa(0), 16'h0FFF);
        rd(wa(2), 1'b1, 16'h1234, "R6 top entry stored");

        // Outside the window (R1)
        acc(1'b1, 1'b1, 16'h31A8, 16'h0000);
        chk(l_pass == 1'b1, "R1 pass above window", 16'(l_pass), 16'h1);
        chk(l_upd == 1'b0, "R1 no update outside window", 16'(l_upd), 16'h0);
        acc(1'b1, 1'b0, 16'h319F, 16'h0000);
        chk(l_pass == 1'b1, "R1 pass below window", 16'(l_pass), 16'h1);
        acc(1'b0, 1'b1, 16'h319E, 16'h0000);
        chk(l_pass == 1'b1, "R1 pass on read outside", 16'(l_pass), 16'h1);
        chk(map_en == 1'b1 && map_bank == 4'h3, "R1 map unchanged", 16'(map_bank), 16'h3);
        rd(wa(0), 1'b1, 16'h0FFF, "R1 index unchanged");
        acc(1'b1, 1'b0, wa(7), 16'h0002);
        chk(l_pass == 1'b0, "R1 no pass inside window", 16'(l_pass), 16'h0);

        // Request during busy is dropped (R9)
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b1; io_word = 1'b1; io_addr = wa(0); io_wdata = 16'h0001;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy seen", 16'(busy), 16'h1);
        io_req = 1'b1; io_wr = 1'b1; io_word = 1'b0; io_addr = wa(7); io_wdata = 16'h0000;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
        chk(io_pass == 1'b0 && upd_valid == 1'b0, "R9 no response to dropped request",
            {14'h0, io_pass, upd_valid}, 16'h0);
        chk(map_en == 1'b1, "R9 dropped control write", 16'(map_en), 16'h1);
        rd(wa(7), 1'b0, 16'h0002, "R9 control unchanged");
        rd(wa(2), 1'b1, 16'hA001, "R4 reload in back-to-back case");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R11 all reads answered", 16'(q.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule